// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose Port with Atomic Set/Clear

This block is the register front end of one general-purpose port of up to sixteen pins. It sits on a plain 32-bit register bus made of an address, a write strobe, write data, a read strobe and registered read data. Three word registers are decoded. An input view at offset 0x10 reports the port pins after a two-flop synchronizer. An output latch at offset 0x14 drives the output pins and can be read back. A write-only set/clear word at offset 0x18 changes any chosen group of output bits in a single bus write, so software never needs a read-modify-write sequence that an interrupt could split.

In the set/clear word, bit y (y = 0..15) set to 1 drives output bit y high. Bit 16+y set to 1 drives output bit y low. A 0 in either half leaves the bit alone. When one write names the same pin in both halves, the set half wins. Writes take effect at the clock edge that samples the strobe. Read data appears in the cycle after the read strobe and is zero in any cycle with no read strobe.

Top module: `gpio_bitport`

## Requirements
- R1: Reset is synchronous and active high. After reset the output pins are 0, the output latch reads 0x0000_0000, and rdata is 0.
- R2: A write to offset 0x14 loads wdata[15:0] into the output latch. A read of 0x14 returns the latch in bits 15:0 and 0 in bits 31:16, whatever was written to wdata[31:16].
- R3: The output pins equal the output latch. A write changes the pins at the same clock edge that samples the write strobe.
- R4: A read of offset 0x10 returns the synchronized pin levels in bits 15:0 and 0 in bits 31:16. A write to 0x10 changes nothing.
- R5: Writing 1 to bit y (0..15) of offset 0x18 sets output bit y to 1.
- R6: Writing 1 to bit 16+y of offset 0x18 clears output bit y to 0.
- R7: An output bit whose set bit and clear bit are both 0 in a write to 0x18 keeps its value. With no write strobe, the outputs do not change.
- R8: If a write to 0x18 has both bit y and bit 16+y at 1, output bit y becomes 1.
- R9: A read of 0x18 returns 0. A read of any unmapped offset returns 0. A write to an unmapped offset changes no output.
- R10: Each pin passes through two synchronizer flops. After a pin changes, reads whose strobe is sampled at the first and second clock edges still return the old level. A read at the third edge returns the new level.
- R11: rdata is registered. It is valid in the cycle after the clock edge that samples rd_en, and it is 0 in any cycle that follows an edge with rd_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW (8) | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| pins_in | input | NPINS (16) | Asynchronous port pin levels |
| pins_out | output | NPINS (16) | Output latch driving the pins |

## Verification
The bench goes after the set/clear collision. A design that let the clear half win, or that applied the two halves in the wrong order, ends with those pins low, and the bench catches it from the pins and from a read-back. It writes all-zero set/clear words and writes to unmapped offsets and to the input view. A design that decoded loosely, or that treated a 0 as a clear, would then disturb the latch. The bench reads back-to-back across a pin change. A synchronizer that is one flop short or one flop long shows the new level at the wrong edge. It also checks the reserved upper halves and the idle read bus, where a design that echoed wdata or held stale read data would leak non-zero bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register byte offsets (software decodes these, so they are fixed)
  localparam logic [31:0] OFF_PIN_VIEW = 32'h10;
  localparam logic [31:0] OFF_OUT_LAT  = 32'h14;
  localparam logic [31:0] OFF_SET_CLR  = 32'h18;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PIN_VIEW,
    SEL_OUT_LAT,
    SEL_SET_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [31:0] off);
    case (off)
      OFF_PIN_VIEW: decode_off = SEL_PIN_VIEW;
      OFF_OUT_LAT:  decode_off = SEL_OUT_LAT;
      OFF_SET_CLR:  decode_off = SEL_SET_CLR;
      default:      decode_off = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         sc_en,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (load_en)
      nxt = load_val;
    else if (sc_en)
      nxt = (q & ~clr_mask) | set_mask;   // clear first, set last: set wins
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux #(
  parameter int W  = 16,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  gpio_pkg::reg_sel_e sel,
  input  logic [W-1:0]       pin_view,
  input  logic [W-1:0]       out_lat,
  output logic [DW-1:0]      rdata
);
  import gpio_pkg::*;

  logic [DW-1:0] mux;

  always_comb begin
    mux = '0;
    case (sel)
      SEL_PIN_VIEW: mux = DW'(pin_view);
      SEL_OUT_LAT:  mux = DW'(out_lat);
      default:      mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mux;
    else            rdata <= '0;
  end

endmodule

// File: rtl/gpio_bitport.sv
module gpio_bitport #(
  parameter int NPINS       = 16,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic             rd_en,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] pins_out
);
  import gpio_pkg::*;

  localparam int HALF = BUS_W / 2;

  reg_sel_e         sel;
  logic [NPINS-1:0] pin_view;
  logic             load_en;
  logic             sc_en;

  assign sel     = decode_off(32'(addr));
  assign load_en = wr_en && (sel == SEL_OUT_LAT);
  assign sc_en   = wr_en && (sel == SEL_SET_CLR);

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_in),
    .dout (pin_view)
  );

  gpio_out_latch #(.W(NPINS)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (wdata[NPINS-1:0]),
    .sc_en    (sc_en),
    .set_mask (wdata[NPINS-1:0]),
    .clr_mask (wdata[HALF+NPINS-1:HALF]),
    .q        (pins_out)
  );

  gpio_rd_mux #(.W(NPINS), .DW(BUS_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .sel      (sel),
    .pin_view (pin_view),
    .out_lat  (pins_out),
    .rdata    (rdata)
  );

endmodule

// File: rtl/gpio_bitport_chk.sv
module gpio_bitport_chk #(
  parameter int NPINS = 16,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic [31:0]      wdata,
  input logic             rd_en,
  input logic [31:0]      rdata,
  input logic [NPINS-1:0] pins_out
);
  import gpio_pkg::*;

  localparam int HALF = BUS_W / 2;

  logic at_lat, at_sc, at_view, at_mapped;
  assign at_lat    = (32'(addr) == OFF_OUT_LAT);
  assign at_sc     = (32'(addr) == OFF_SET_CLR);
  assign at_view   = (32'(addr) == OFF_PIN_VIEW);
  assign at_mapped = at_lat || at_sc || at_view;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pins_out == '0 && rdata == '0));

  // R2, R3
  a_r3_latch_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && at_lat) |=> pins_out == $past(wdata[NPINS-1:0]));

  // R5, R6, R8
  a_r8_set_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && at_sc) |=> pins_out ==
      (($past(pins_out) & ~$past(wdata[HALF+NPINS-1:HALF])) | $past(wdata[NPINS-1:0])));

  // R7
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pins_out));

  // R4, R9
  a_r9_dead_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (at_view || !at_mapped)) |=> $stable(pins_out));

  a_r9_zero_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (at_sc || !at_mapped)) |=> rdata == '0);

  // R4
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (at_view || at_lat)) |=> rdata[31:HALF] == '0);

  // R11
  a_r11_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);

endmodule

bind gpio_bitport gpio_bitport_chk #(.NPINS(NPINS), .AW(AW)) u_chk (.*);

// File: tb/tb_gpio_bitport.sv
`timescale 1ns/1ps
module tb_gpio_bitport;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [15:0] pins_in = '0;
  logic [15:0] pins_out;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bitport dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out)
  );

  // {addr, wdata, expected pins after the write}
  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {8'h14, 32'hFFFF_A5C3, 16'hA5C3},  // R2 R3: upper half ignored
    {8'h18, 32'h0000_0004, 16'hA5C7},  // R5: set bit 2
    {8'h18, 32'h8001_0000, 16'h25C6},  // R6: clear bits 15 and 0
    {8'h18, 32'h0000_0000, 16'h25C6},  // R7: no bit named
    {8'h18, 32'h00F0_00F0, 16'h25F6},  // R8: bits 7:4 in both halves
    {8'h18, 32'hFFFF_0000, 16'h0000},  // R6: clear all
    {8'h18, 32'hFFFF_FFFF, 16'hFFFF},  // R8: all named twice
    {8'h18, 32'h0F0F_0000, 16'hF0F0},  // R6 R7: partial clear
    {8'h1C, 32'h0000_0000, 16'hF0F0},  // R9: unmapped write
    {8'h10, 32'h0000_0000, 16'hF0F0}   // R4: write to input view
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call at a negedge; returns at a negedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pins_out after reset", 32'(pins_out), 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    bus_read(8'h14, r);
    check("R1 latch reads zero", r, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][55:48], VEC[i][47:16]);
      check("R3/R5-R9 table pins", 32'(pins_out), 32'(VEC[i][15:0]));
      bus_read(8'h14, r);
      check("R2 table readback", r, {16'h0, VEC[i][15:0]});
    end

    // R11: idle bus after a read
    @(negedge clk);
    check("R11 rdata idle zero", rdata, 32'h0);

    // R9: zero reads
    bus_read(8'h18, r);
    check("R9 set/clear reads zero", r, 32'h0);
    bus_read(8'h00, r);
    check("R9 unmapped read zero", r, 32'h0);
    bus_read(8'h1C, r);
    check("R9 unmapped 0x1C read zero", r, 32'h0);
    check("R9 reads left pins", 32'(pins_out), 32'h0000_F0F0);

    // R4: input view
    pins_in = 16'h1234;
    repeat (4) @(negedge clk);
    bus_read(8'h10, r);
    check("R4 input view", r, 32'h0000_1234);

    // R10: synchronizer depth, back-to-back reads
    pins_in = 16'hBEEF;
    bus_read(8'h10, r);
    check("R10 first edge old", r, 32'h0000_1234);
    bus_read(8'h10, r);
    check("R10 second edge old", r, 32'h0000_1234);
    bus_read(8'h10, r);
    check("R10 third edge new", r, 32'h0000_BEEF);

    // R8: single-pin collision on a low pin
    bus_write(8'h14, 32'h0000_0000);
    bus_write(8'h18, 32'h0001_0001);
    check("R8 bit0 set wins", 32'(pins_out), 32'h0000_0001);

    // R7: collision on one pin leaves the others
    bus_write(8'h18, 32'h8000_8000);
    check("R7 R8 others kept", 32'(pins_out), 32'h0000_8001);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears pins", 32'(pins_out), 32'h0);

    done = 1'b1;
    summary();
  end

endmodule